// File: doc/BRIEF.md
# Continuous-Conversion ADC Serial Reader

This block is the host-side serial master for a delta-sigma converter that is left converting without pause. A start pulse makes it send one command byte that names one of eight setup registers. The block then watches the converter's data-out line, which also serves as the data-ready flag. When the line goes low, the block runs a 40-clock read frame. The first eight clocks of the frame clear the flag, and the byte sent during them tells the converter either to keep going or to leave the mode. The last thirty-two clocks carry the result.

The first few results after a start come from a filter that has not yet settled. The block drops them. The number dropped depends on whether the output rate is high or low. The results that remain are offered on a valid/ready port. Back-pressure cannot stall the converter: a result the consumer has not taken is replaced by the next one, and a sticky overrun flag records the loss. A stop request takes effect in the flag-clear phase of the next frame. `busy` stays high until that last frame has been read.

Top module: `adc_cc_reader`

## Requirements
- R1: When `start` is high while `busy` is low, the block sends the command byte {2'b11, setup_ptr, 3'b000} on `sdi`, most significant bit first, over 8 `sclk` periods. A `start` while `busy` is high is ignored.
- R2: `sclk` is low whenever `busy` is low. Each `sclk` period lasts CLK_DIV system clocks, low for the first CLK_DIV/2 and high for the rest. `sdi` changes only while `sclk` is low.
- R3: After the command, and again after every frame, the block waits until the synchronised `sdo` has been seen high and then low. Only then does it start a 40-clock read frame. This wait has no time limit.
- R4: The byte sent during the first 8 clocks of a frame is 0x00 to continue, or 0xFF when a stop is pending. A `stop` that arrives during a frame is applied in the next frame, so the frame in progress still sends 0x00.
- R5: A frame's result is the last 32 bits sampled from `sdo`, most significant bit first.
- R6: After each accepted start, the first DISC_LO results (3 by default) are dropped when `hi_rate` was 0, and the first DISC_HI results (5 by default) are dropped when it was 1. Every later result is delivered, in order.
- R7: `res_valid` stays high with its data until `res_ready` is high. If a new result arrives while the previous one is unaccepted, the new one replaces it and `overrun` is set. `overrun` stays set until the next accepted start.
- R8: `busy` rises only after an accepted start. It falls only after the exit frame has completed. The exit frame's result is delivered like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that starts continuous reading |
| setup_ptr | input | 3 | Setup register selected by the command byte |
| hi_rate | input | 1 | 1 when the output rate is 3200 samples/s or more |
| stop | input | 1 | Request to leave continuous mode |
| busy | output | 1 | High from an accepted start until the exit frame ends |
| sclk | output | 1 | Serial clock to the converter |
| sdi | output | 1 | Serial data to the converter |
| sdo | input | 1 | Serial data and ready flag from the converter |
| res_data | output | 32 | Conversion result |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| overrun | output | 1 | Sticky flag: an unaccepted result was replaced |

## Verification
The assertions check the following on every cycle: `sclk` stays quiet while idle, `sdi` holds while `sclk` is high, the result is held under back-pressure, `overrun` is sticky and is only set by a replaced result, and `busy` only rises after a start. The bench's scenarios, run against a behavioural converter model, are needed for the rest: the command byte contents, the 0x00 and 0xFF flag bytes, the exact count of dropped results for each rate, and the one-frame delay when stop arrives mid-frame. The same applies to the match between delivered words and the words the model shipped.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int FLAG_BITS  = 8;
  localparam int RES_W      = 32;
  localparam int FRAME_BITS = FLAG_BITS + RES_W;
  localparam logic [7:0] FLAG_GO   = 8'h00;
  localparam logic [7:0] FLAG_EXIT = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WHI,
    ST_WLO,
    ST_FRM
  } seq_st_t;

  function automatic logic [7:0] cmd_byte(input logic [2:0] ptr);
    return {2'b11, ptr, 3'b000};
  endfunction
endpackage

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int CLK_DIV = 4,
  parameter int TX_W    = 8,
  parameter int RX_W    = 32,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] nbits,
  input  logic [TX_W-1:0]  txd,
  input  logic             sdo_s,
  output logic             busy,
  output logic             done,
  output logic [RX_W-1:0]  rxd,
  output logic             sclk,
  output logic             sdi
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = $clog2(CLK_DIV);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] left_q;
  logic [TX_W-1:0]  tx_q;
  logic [RX_W-1:0]  rx_q;
  logic             busy_q, done_q, sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      left_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (go) begin
          busy_q <= 1'b1;
          left_q <= nbits;
          tx_q   <= txd;
          div_q  <= '0;
        end
      end else if (div_q == DIV_W'(CLK_DIV - 1)) begin
        // end of the high phase: sample, drop the clock, advance the bit
        div_q  <= '0;
        sclk_q <= 1'b0;
        rx_q   <= {rx_q[RX_W-2:0], sdo_s};
        tx_q   <= {tx_q[TX_W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
        if (left_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else begin
        div_q <= div_q + 1'b1;
        if (div_q == DIV_W'(HALF - 1)) sclk_q <= 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign rxd  = rx_q;
  assign sclk = sclk_q;
  assign sdi  = tx_q[TX_W-1];
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DISC_LO = 3,
  parameter int DISC_HI = 5,
  parameter int CNT_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       setup_ptr,
  input  logic             hi_rate,
  input  logic             stop,
  input  logic             sdo_s,
  input  logic             eng_done,
  input  logic [RES_W-1:0] eng_rxd,
  output logic             eng_go,
  output logic [CNT_W-1:0] eng_nbits,
  output logic [7:0]       eng_txd,
  output logic             push,
  output logic [RES_W-1:0] push_data,
  output logic             busy,
  output logic             clr_ovr
);
  localparam int DMAX  = (DISC_HI > DISC_LO) ? DISC_HI : DISC_LO;
  localparam int DISC_W = $clog2(DMAX + 1);

  seq_st_t          st_q;
  logic [DISC_W-1:0] disc_q;
  logic             pend_q, exit_q;
  logic             stop_now;

  assign stop_now = pend_q | stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      disc_q    <= '0;
      pend_q    <= 1'b0;
      exit_q    <= 1'b0;
      eng_go    <= 1'b0;
      eng_nbits <= '0;
      eng_txd   <= '0;
      push      <= 1'b0;
      push_data <= '0;
    end else begin
      eng_go <= 1'b0;
      push   <= 1'b0;
      pend_q <= stop_now;
      case (st_q)
        ST_IDLE: begin
          pend_q <= 1'b0;
          if (start) begin
            eng_go    <= 1'b1;
            eng_nbits <= CNT_W'(FLAG_BITS);
            eng_txd   <= cmd_byte(setup_ptr);
            disc_q    <= hi_rate ? DISC_W'(DISC_HI) : DISC_W'(DISC_LO);
            st_q      <= ST_CMD;
          end
        end
        ST_CMD: if (eng_done) st_q <= ST_WHI;
        ST_WHI: if (sdo_s) st_q <= ST_WLO;
        ST_WLO: begin
          if (!sdo_s) begin
            eng_go    <= 1'b1;
            eng_nbits <= CNT_W'(FRAME_BITS);
            eng_txd   <= stop_now ? FLAG_EXIT : FLAG_GO;
            exit_q    <= stop_now;
            pend_q    <= 1'b0;
            st_q      <= ST_FRM;
          end
        end
        ST_FRM: begin
          if (eng_done) begin
            if (disc_q != '0) begin
              disc_q <= disc_q - 1'b1;
            end else begin
              push      <= 1'b1;
              push_data <= eng_rxd;
            end
            st_q <= exit_q ? ST_IDLE : ST_WHI;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign clr_ovr = start && (st_q == ST_IDLE);
endmodule

// File: rtl/adc_rd_out.sv
module adc_rd_out #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         clr,
  input  logic         res_ready,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         overrun
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      overrun   <= 1'b0;
    end else begin
      if (push) begin
        res_valid <= 1'b1;
        res_data  <= push_data;
        if (res_valid && !res_ready) overrun <= 1'b1;
      end else if (res_valid && res_ready) begin
        res_valid <= 1'b0;
      end
      if (clr) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_cc_reader.sv
module adc_cc_reader
  import adc_rd_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DISC_LO     = 3,
  parameter int DISC_HI     = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  setup_ptr,
  input  logic        hi_rate,
  input  logic        stop,
  output logic        busy,
  output logic        sclk,
  output logic        sdi,
  input  logic        sdo,
  output logic [31:0] res_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic        overrun
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   sdo_s;
  logic                   eng_go, eng_busy, eng_done;
  logic [CNT_W-1:0]       eng_nbits;
  logic [7:0]             eng_txd;
  logic [RES_W-1:0]       eng_rxd;
  logic                   push, clr_ovr;
  logic [RES_W-1:0]       push_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], sdo};
  end
  assign sdo_s = sync_q[SYNC_STAGES-1];

  adc_rd_shift #(
    .CLK_DIV(CLK_DIV), .TX_W(8), .RX_W(RES_W), .CNT_W(CNT_W)
  ) u_shift (
    .clk(clk), .rst_n(rst_n), .go(eng_go), .nbits(eng_nbits), .txd(eng_txd),
    .sdo_s(sdo_s), .busy(eng_busy), .done(eng_done), .rxd(eng_rxd),
    .sclk(sclk), .sdi(sdi)
  );

  adc_rd_seq #(
    .DISC_LO(DISC_LO), .DISC_HI(DISC_HI), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .setup_ptr(setup_ptr),
    .hi_rate(hi_rate), .stop(stop), .sdo_s(sdo_s), .eng_done(eng_done),
    .eng_rxd(eng_rxd), .eng_go(eng_go), .eng_nbits(eng_nbits),
    .eng_txd(eng_txd), .push(push), .push_data(push_data), .busy(busy),
    .clr_ovr(clr_ovr)
  );

  adc_rd_out #(.W(RES_W)) u_out (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .clr(clr_ovr), .res_ready(res_ready), .res_valid(res_valid),
    .res_data(res_data), .overrun(overrun)
  );

  logic unused_ok;
  assign unused_ok = eng_busy;
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        sclk,
  input logic        sdi,
  input logic        res_valid,
  input logic        res_ready,
  input logic        overrun
);
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R2
  sdi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdi));

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid);

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !(start && !busy) |=> overrun);

  // R7
  ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(res_valid && !res_ready));

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind adc_cc_reader adc_rd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .sclk(sclk),
  .sdi(sdi), .res_valid(res_valid), .res_ready(res_ready), .overrun(overrun)
);

// File: tb/sim_adc_cc_reader.sv
module sim_adc_cc_reader;
  localparam int CLKDIV = 6;
  localparam int DLO = 3;
  localparam int DHI = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, hi_rate = 1'b0, stop = 1'b0, res_ready = 1'b0;
  logic [2:0] setup_ptr = '0;
  logic busy, sclk, sdi, res_valid, overrun;
  logic [31:0] res_data;
  logic sdo;

  int checks = 0, errors = 0;
  bit finished = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  adc_cc_reader #(.CLK_DIV(CLKDIV), .DISC_LO(DLO), .DISC_HI(DHI)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .setup_ptr(setup_ptr),
    .hi_rate(hi_rate), .stop(stop), .busy(busy), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .res_data(res_data), .res_valid(res_valid),
    .res_ready(res_ready), .overrun(overrun)
  );

  // ---------------- converter model ----------------
  logic [7:0]  cmd_q[$];
  logic [7:0]  flag_q[$];
  logic [31:0] ship_q[$];
  logic [31:0] rx_q[$];
  logic        m_cmd = 1'b1, m_prev = 1'b0, m_first = 1'b1;
  logic [7:0]  m_byte = '0;
  logic [2:0]  m_ptr = '0;
  logic [31:0] m_word = '0;
  int          m_rcnt = 0, m_timer = 0, m_idx = 0;

  assign sdo = m_sdo;
  logic m_sdo = 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && res_valid && res_ready) rx_q.push_back(res_data);
    if (!rst_n) begin
      m_cmd <= 1'b1; m_prev <= 1'b0; m_sdo <= 1'b1; m_rcnt <= 0;
    end else begin
      m_prev <= sclk;
      if (sclk && !m_prev) begin
        m_rcnt <= m_rcnt + 1;
        if (m_rcnt < 8) m_byte <= {m_byte[6:0], sdi};
      end else if (!sclk && m_prev) begin
        if (m_cmd) begin
          if (m_rcnt == 8) begin
            cmd_q.push_back(m_byte);
            m_ptr <= m_byte[5:3];
            m_rcnt <= 0; m_cmd <= 1'b0; m_sdo <= 1'b1;
            m_timer <= 0; m_first <= 1'b1;
          end
        end else if (m_rcnt == 40) begin
          ship_q.push_back(m_word);
          flag_q.push_back(m_byte);
          m_rcnt <= 0; m_sdo <= 1'b1;
          if (m_byte == 8'hFF) m_cmd <= 1'b1;
        end else begin
          m_sdo <= (m_rcnt < 8) ? 1'b0 : m_word[39 - m_rcnt];
        end
      end
      if (!m_cmd && m_rcnt == 0) begin
        if (m_timer >= (m_first ? 1000 : 500)) begin
          m_timer <= 0; m_first <= 1'b0; m_idx <= m_idx + 1;
          m_word <= 32'hC000_0000 | ({29'd0, m_ptr} << 20) | 32'(m_idx);
          m_sdo <= 1'b0;
        end else begin
          m_timer <= m_timer + 1;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_q();
    cmd_q.delete(); flag_q.delete(); ship_q.delete(); rx_q.delete();
  endtask

  task automatic pulse_start(input logic [2:0] p, input logic hr);
    setup_ptr = p; hi_rate = hr; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    cycles(6);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R2 sclk at reset", 64'(sclk), 64'd0);
    chk("R8 busy at reset", 64'(busy), 64'd0);
    chk("R7 valid at reset", 64'(res_valid), 64'd0);
    chk("R7 overrun at reset", 64'(overrun), 64'd0);
  endtask

  task automatic t_session(input logic [2:0] p, input logic hr, input int nkeep);
    int disc = hr ? DHI : DLO;
    int hi_n = 0, lo_n = 0;
    clear_q();
    res_ready = 1'b1;
    pulse_start(p, hr);
    chk("R8 busy after start", 64'(busy), 64'd1);
    // R2: measure one sclk period during the command
    for (int i = 0; i < 100 && !sclk; i++) @(negedge clk);
    while (sclk) begin hi_n++; @(negedge clk); end
    while (!sclk) begin lo_n++; @(negedge clk); end
    chk("R2 sclk high time", 64'(hi_n), 64'(CLKDIV - CLKDIV / 2));
    chk("R2 sclk low time", 64'(lo_n), 64'(CLKDIV / 2));
    for (int i = 0; i < 2000 && cmd_q.size() == 0; i++) @(negedge clk);
    chk("R1 command count", 64'(cmd_q.size()), 64'd1);
    if (cmd_q.size() > 0) chk("R1 command byte", 64'(cmd_q[0]), 64'({2'b11, p, 3'b000}));
    pulse_start(~p, ~hr);  // R1: must be ignored while busy
    for (int i = 0; i < 40000 && rx_q.size() < nkeep; i++) @(negedge clk);
    chk("R6 delivered count", 64'(rx_q.size() >= nkeep), 64'd1);
    for (int i = 0; i < nkeep && i < rx_q.size(); i++)
      chk("R5 R6 delivered word", 64'(rx_q[i]), 64'(ship_q[i + disc]));
    for (int i = 0; i < flag_q.size(); i++)
      chk("R4 continue byte", 64'(flag_q[i]), 64'h00);
    pulse_stop();
    wait_idle();
    chk("R8 idle after exit", 64'(busy), 64'd0);
    chk("R1 second start ignored", 64'(cmd_q.size()), 64'd1);
    chk("R4 exit byte", 64'(flag_q[flag_q.size() - 1]), 64'hFF);
    chk("R8 exit frame delivered", 64'(rx_q[rx_q.size() - 1]), 64'(ship_q[ship_q.size() - 1]));
    chk("R6 total delivered", 64'(rx_q.size()), 64'(ship_q.size() - disc));
  endtask

  task automatic t_midstop();
    int n;
    clear_q();
    res_ready = 1'b1;
    pulse_start(3'd1, 1'b0);
    for (int i = 0; i < 40000 && ship_q.size() < 4; i++) @(negedge clk);
    for (int i = 0; i < 2000 && m_rcnt < 12; i++) @(negedge clk);
    n = flag_q.size();
    pulse_stop();
    wait_idle();
    chk("R4 frames after mid stop", 64'(flag_q.size()), 64'(n + 2));
    if (flag_q.size() >= n + 2) begin
      chk("R4 current frame continues", 64'(flag_q[n]), 64'h00);
      chk("R4 next frame exits", 64'(flag_q[n + 1]), 64'hFF);
    end
  endtask

  task automatic t_overrun();
    clear_q();
    res_ready = 1'b0;
    pulse_start(3'd3, 1'b0);
    for (int i = 0; i < 40000 && ship_q.size() < DLO + 1; i++) @(negedge clk);
    cycles(8);
    chk("R7 first word valid", 64'(res_valid), 64'd1);
    chk("R7 no overrun yet", 64'(overrun), 64'd0);
    chk("R3 R5 first kept word", 64'(res_data), 64'(ship_q[DLO]));
    for (int i = 0; i < 40000 && ship_q.size() < DLO + 2; i++) @(negedge clk);
    cycles(8);
    chk("R7 overrun set", 64'(overrun), 64'd1);
    chk("R7 newest word kept", 64'(res_data), 64'(ship_q[DLO + 1]));
    res_ready = 1'b1; @(negedge clk); res_ready = 1'b0;
    chk("R7 valid drops after accept", 64'(res_valid), 64'd0);
    chk("R7 overrun sticky", 64'(overrun), 64'd1);
    pulse_stop();
    wait_idle();
    pulse_start(3'd0, 1'b0);
    cycles(2);
    chk("R7 overrun cleared by start", 64'(overrun), 64'd0);
    pulse_stop();
    wait_idle();
    res_ready = 1'b1;
  endtask

  initial begin
    cycles(5);
    rst_n = 1'b1;
    cycles(3);
    t_reset();
    t_session(3'd5, 1'b0, 4);
    t_session(3'd2, 1'b1, 3);
    t_midstop();
    t_overrun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule